// File: doc/BRIEF.md
# Wrapping Pointer Update Unit

This block holds a small bank of 16-bit data pointers for a signal-processing datapath. Every pointer has its own signed stride register and its own wrap-mask register, and both share the pointer's number. An update command asks for one of three steps on a pointer: move back by one, move forward by one, or move by the pointer's stride. The step wraps inside the power-of-two window that the mask sets, so a pointer can sweep a circular buffer without software fixing it up.

Two update lanes work in the same cycle. A paired load/store can therefore move two pointers together, each with its own step kind. Each lane hands back the value it computed one cycle later. A single configuration write port loads a pointer, a stride or a mask. Opcode decoding and memory access are outside this block.

Top module: `wrap_ptr_unit`

## Requirements
- R1: After reset every pointer and every stride reads 0, every mask is all ones, and no lane result is valid.
- R2: Step code 2'b00 (back): if (P & M) == 0 the new pointer is P | M, otherwise it is P - 1.
- R3: Step code 2'b01 (forward): if (P & M) == M the new pointer is P & ~M, otherwise it is P + 1.
- R4: Step code 2'b10 with a stride S whose bit 15 is 0: the new pointer is ((P + (S & ~M)) & ~M) | ((P + S) & M).
- R5: Step code 2'b10 with bit 15 of S set: take the magnitude N = -S, and the new pointer is ((P - (N & ~M)) & ~M) | ((P - N) & M).
- R6: With the reset mask (all ones), back from 0 gives 0xFFFF and forward from 0xFFFF gives 0, which is plain modulo-65536 arithmetic.
- R7: Both lanes may act in one cycle on different pointers, each with its own step code. Lane p picks its pointer from upd_sel bits [2p+1:2p] and its code from upd_op bits [2p+1:2p]. One cycle after the command, res_vld[p] is 1 and res_val bits [16p+15:16p] hold the computed value.
- R8: A configuration write to a pointer (cfg_tgt 2'b00) overrides a lane update of the same pointer in the same cycle. The lane still reports the value it computed.
- R9: When both lanes name the same pointer, lane 0's value is stored. Both lanes still report their own computed values.
- R10: Step code 2'b11 (hold) leaves the pointer unchanged and reports its current value.
- R11: cfg_tgt 2'b01 writes the stride and 2'b10 writes the mask of pointer cfg_sel. Later steps use the new values. cfg_tgt 2'b11 changes nothing.
- R12: A pointer that no lane and no configuration write addresses keeps its value. ptr_val bits [16i+15:16i] show pointer i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_vld | input | 2 | Per-lane command valid |
| upd_sel | input | 4 | Per-lane pointer number, 2 bits each |
| upd_op | input | 4 | Per-lane step code, 2 bits each |
| cfg_we | input | 1 | Configuration write enable |
| cfg_tgt | input | 2 | Write target: pointer, stride, mask, none |
| cfg_sel | input | 2 | Register number to write |
| cfg_data | input | 16 | Value to write |
| res_vld | output | 2 | Per-lane result valid, one cycle after the command |
| res_val | output | 32 | Per-lane computed value, 16 bits each |
| ptr_val | output | 64 | Current value of all four pointers |

## Verification
The bench drives the pointer across both edges of a narrow window in each direction. An off-by-one in the wrap test would step out of the window, for example 0x107 to 0x108, or skip its far end. For strides it checks negative values and strides larger than the window. A design that treats a negative stride as a large unsigned number, or that wraps the upper bits, gives a visibly different pointer. Collisions are also exercised: both lanes on one pointer, and a configuration write racing a lane. With the wrong priority the losing value ends up in the pointer. A write to the unused target is also applied, and must leave every pointer and the later steps unchanged.

// File: rtl/aru_pkg.sv
package aru_pkg;

    typedef enum logic [1:0] {
        STEP_BACK = 2'b00,
        STEP_FWD  = 2'b01,
        STEP_IDX  = 2'b10,
        STEP_HOLD = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        TGT_PTR  = 2'b00,
        TGT_IDX  = 2'b01,
        TGT_WRAP = 2'b10,
        TGT_NONE = 2'b11
    } tgt_e;

endpackage

// File: rtl/aru_step.sv
module aru_step
    import aru_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] cur_i,
    input  logic [DW-1:0] idx_i,
    input  logic [DW-1:0] wrap_i,
    input  step_e         op_i,
    output logic [DW-1:0] nxt_o
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] back_v, fwd_v, idx_v, mag, hi, lo;

    always_comb begin
        // single back/forward steps wrap at the window edge
        back_v = ((cur_i & wrap_i) == '0) ? (cur_i | wrap_i) : (cur_i - ONE);
        fwd_v  = ((cur_i & wrap_i) == wrap_i) ? (cur_i & ~wrap_i) : (cur_i + ONE);

        // stride: window bits wrap, upper bits take the plain sum of the upper part
        mag = idx_i[DW-1] ? (~idx_i + ONE) : idx_i;
        if (idx_i[DW-1]) begin
            hi = (cur_i - (mag & ~wrap_i)) & ~wrap_i;
            lo = (cur_i - mag) & wrap_i;
        end else begin
            hi = (cur_i + (idx_i & ~wrap_i)) & ~wrap_i;
            lo = (cur_i + idx_i) & wrap_i;
        end
        idx_v = hi | lo;

        case (op_i)
            STEP_BACK: nxt_o = back_v;
            STEP_FWD:  nxt_o = fwd_v;
            STEP_IDX:  nxt_o = idx_v;
            default:   nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/aru_lane.sv
module aru_lane
    import aru_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NPTR = 4,
    localparam int SW  = $clog2(NPTR)
) (
    input  logic [NPTR*DW-1:0] ptr_all_i,
    input  logic [NPTR*DW-1:0] idx_all_i,
    input  logic [NPTR*DW-1:0] wrap_all_i,
    input  logic [SW-1:0]      sel_i,
    input  logic [1:0]         op_i,
    output logic [DW-1:0]      nxt_o
);
    logic [DW-1:0] cur, idx, wrap;

    always_comb begin
        cur  = ptr_all_i[int'(sel_i)*DW +: DW];
        idx  = idx_all_i[int'(sel_i)*DW +: DW];
        wrap = wrap_all_i[int'(sel_i)*DW +: DW];
    end

    aru_step #(.DW(DW)) u_step (
        .cur_i  (cur),
        .idx_i  (idx),
        .wrap_i (wrap),
        .op_i   (step_e'(op_i)),
        .nxt_o  (nxt_o)
    );
endmodule

// File: rtl/wrap_ptr_unit.sv
module wrap_ptr_unit
    import aru_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NPTR  = 4,
    parameter int NPORT = 2,
    localparam int SW   = $clog2(NPTR)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      upd_vld,
    input  logic [NPORT*SW-1:0]   upd_sel,
    input  logic [NPORT*2-1:0]    upd_op,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_tgt,
    input  logic [SW-1:0]         cfg_sel,
    input  logic [DW-1:0]         cfg_data,
    output logic [NPORT-1:0]      res_vld,
    output logic [NPORT*DW-1:0]   res_val,
    output logic [NPTR*DW-1:0]    ptr_val
);
    typedef struct packed {
        logic [NPTR-1:0][DW-1:0]  ptr;
        logic [NPTR-1:0][DW-1:0]  idx;
        logic [NPTR-1:0][DW-1:0]  wrap;
        logic [NPORT-1:0]         rvld;
        logic [NPORT-1:0][DW-1:0] rval;
    } st_t;

    st_t st_d, st_q;
    logic [NPORT-1:0][DW-1:0] lane_nxt;

    for (genvar p = 0; p < NPORT; p++) begin : g_lane
        aru_lane #(.DW(DW), .NPTR(NPTR)) u_lane (
            .ptr_all_i  (st_q.ptr),
            .idx_all_i  (st_q.idx),
            .wrap_all_i (st_q.wrap),
            .sel_i      (upd_sel[p*SW +: SW]),
            .op_i       (upd_op[p*2 +: 2]),
            .nxt_o      (lane_nxt[p])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NPORT; p++) begin
            st_d.rvld[p] = upd_vld[p];
            if (upd_vld[p]) st_d.rval[p] = lane_nxt[p];
        end
        // highest lane applied first so lane 0 lands last and wins
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (upd_vld[p]) st_d.ptr[upd_sel[p*SW +: SW]] = lane_nxt[p];
        end
        // configuration write overrides any lane
        if (cfg_we) begin
            case (tgt_e'(cfg_tgt))
                TGT_PTR:  st_d.ptr[cfg_sel]  = cfg_data;
                TGT_IDX:  st_d.idx[cfg_sel]  = cfg_data;
                TGT_WRAP: st_d.wrap[cfg_sel] = cfg_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.idx  <= '0;
            st_q.wrap <= '1;
            st_q.rvld <= '0;
            st_q.rval <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld = st_q.rvld;
    assign res_val = st_q.rval;
    assign ptr_val = st_q.ptr;
endmodule

// File: rtl/aru_chk.sv
module aru_chk
    import aru_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NPTR  = 4,
    parameter int NPORT = 2,
    localparam int SW   = $clog2(NPTR)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NPORT-1:0]    upd_vld,
    input logic [SW-1:0]       sel0,
    input logic                cfg_we,
    input logic [1:0]          cfg_tgt,
    input logic [SW-1:0]       cfg_sel,
    input logic [DW-1:0]       cfg_data,
    input logic [NPORT-1:0]    res_vld,
    input logic [DW-1:0]       res0,
    input logic [NPTR*DW-1:0]  ptr_val
);
    logic          wr_q, hit_q;
    logic [SW-1:0] wsel_q, s0_q;
    logic [DW-1:0] wdat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0; hit_q <= 1'b0;
            wsel_q <= '0; s0_q <= '0; wdat_q <= '0;
        end else begin
            wr_q   <= cfg_we && (cfg_tgt == TGT_PTR);
            hit_q  <= cfg_we && (cfg_tgt == TGT_PTR) && (cfg_sel == sel0);
            wsel_q <= cfg_sel;
            s0_q   <= sel0;
            wdat_q <= cfg_data;
        end
    end

    p_res_follows_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_vld == $past(upd_vld)));

    p_cfg_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> (ptr_val[int'(wsel_q)*DW +: DW] == wdat_q));

    p_lane0_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld[0] && !hit_q) |-> (ptr_val[int'(s0_q)*DW +: DW] == res0));

    p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((upd_vld == '0) && !(cfg_we && cfg_tgt == TGT_PTR)) |=> $stable(ptr_val));
endmodule

bind wrap_ptr_unit aru_chk #(.DW(DW), .NPTR(NPTR), .NPORT(NPORT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_vld  (upd_vld),
    .sel0     (upd_sel[SW-1:0]),
    .cfg_we   (cfg_we),
    .cfg_tgt  (cfg_tgt),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .res_vld  (res_vld),
    .res0     (res_val[DW-1:0]),
    .ptr_val  (ptr_val)
);

// File: tb/wrap_ptr_unit_test.sv
`timescale 1ns/1ps
module wrap_ptr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  upd_vld = '0;
    logic [3:0]  upd_sel = '0;
    logic [3:0]  upd_op = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_tgt = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic [1:0]  res_vld;
    logic [31:0] res_val;
    logic [63:0] ptr_val;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct { int lane; logic [15:0] val; string tag; } item_t;
    item_t sb[$];

    logic [15:0] m_ptr [4];
    logic [15:0] m_idx [4];
    logic [15:0] m_wrap[4];

    always #2.5 clk = ~clk;

    wrap_ptr_unit uut (
        .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .upd_sel(upd_sel),
        .upd_op(upd_op), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .res_vld(res_vld), .res_val(res_val), .ptr_val(ptr_val)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // expected step value, window part and upper part worked out separately
    function automatic logic [15:0] model_step(logic [15:0] p, logic [15:0] s,
                                               logic [15:0] m, logic [1:0] op);
        logic [15:0] n, win, up;
        case (op)
            2'b00: return ((p & m) == 16'h0) ? (p | m) : p - 16'd1;
            2'b01: return ((p & m) == m) ? (p & ~m) : p + 16'd1;
            2'b10: begin
                if (!s[15]) begin
                    win = ((p & m) + (s & m)) & m;
                    up  = ((p & ~m) + (s & ~m)) & ~m;
                end else begin
                    n   = 16'd0 - s;
                    win = ((p & m) - (n & m)) & m;
                    up  = ((p & ~m) - (n & ~m)) & ~m;
                end
                return up | win;
            end
            default: return p;
        endcase
    endfunction

    task automatic cyc(string tag, bit v0, int s0, logic [1:0] o0,
                       bit v1, int s1, logic [1:0] o1,
                       bit we, logic [1:0] tgt, int cs, logic [15:0] cd);
        logic [15:0] r0, r1;
        @(negedge clk);
        upd_vld = {v1, v0};
        upd_sel = {2'(s1), 2'(s0)};
        upd_op  = {o1, o0};
        cfg_we = we; cfg_tgt = tgt; cfg_sel = 2'(cs); cfg_data = cd;
        r0 = model_step(m_ptr[s0], m_idx[s0], m_wrap[s0], o0);
        r1 = model_step(m_ptr[s1], m_idx[s1], m_wrap[s1], o1);
        if (v0) sb.push_back('{0, r0, tag});
        if (v1) sb.push_back('{1, r1, tag});
        if (v1) m_ptr[s1] = r1;
        if (v0) m_ptr[s0] = r0;
        if (we) begin
            case (tgt)
                2'b00: m_ptr[cs]  = cd;
                2'b01: m_idx[cs]  = cd;
                2'b10: m_wrap[cs] = cd;
                default: ;
            endcase
        end
        @(posedge clk);
        #2;
        upd_vld = '0; cfg_we = 1'b0;
        for (int i = 0; i < 4; i++)
            check({tag, " ptr"}, ptr_val[i*16 +: 16], m_ptr[i]);
    endtask

    // monitor: pops expected lane results as the design produces them
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                for (int p = 0; p < 2; p++) begin
                    if (res_vld[p]) begin
                        if (sb.size() == 0) begin
                            n_tests++; n_fail++;
                            $display("FAIL R7: unexpected result lane %0d got %h expected none",
                                     p, res_val[p*16 +: 16]);
                        end else begin
                            it = sb.pop_front();
                            n_tests++;
                            if (it.lane != p || res_val[p*16 +: 16] !== it.val) begin
                                n_fail++;
                                $display("FAIL %s: lane %0d got %h expected lane %0d %h",
                                         it.tag, p, res_val[p*16 +: 16], it.lane, it.val);
                            end
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_ptr[i] = '0; m_idx[i] = '0; m_wrap[i] = 16'hFFFF;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 res_vld", {14'd0, res_vld}, 16'd0);
        for (int i = 0; i < 4; i++) check("R1 ptr", ptr_val[i*16 +: 16], 16'h0000);

        // R6: default mask gives modulo arithmetic; R7 both lanes at once
        cyc("R6 back from zero", 1, 1, 2'b00, 1, 2, 2'b01, 0, 2'b00, 0, 16'h0);
        check("R6 back value", ptr_val[16 +: 16], 16'hFFFF);
        cyc("R6 fwd from top", 1, 1, 2'b01, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        check("R6 fwd value", ptr_val[16 +: 16], 16'h0000);
        cyc("R1 stride zero", 1, 2, 2'b10, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);

        // R11: mask and pointer setup, window of 8 on pointer 0
        cyc("R11 mask0", 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b10, 0, 16'h0007);
        cyc("R11 ptr0", 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b00, 0, 16'h0105);
        // R3: forward across the top of the window
        cyc("R3 fwd", 1, 0, 2'b01, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        cyc("R3 fwd", 1, 0, 2'b01, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        cyc("R3 fwd wrap", 1, 0, 2'b01, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        check("R3 wrapped value", ptr_val[0 +: 16], 16'h0100);
        // R2: back across the bottom of the window
        cyc("R2 back wrap", 1, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        check("R2 wrapped value", ptr_val[0 +: 16], 16'h0107);
        cyc("R2 back", 1, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);

        // R4: positive strides, inside and larger than the window
        cyc("R11 idx0", 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b01, 0, 16'h0003);
        cyc("R4 stride 3", 1, 0, 2'b10, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        check("R4 value", ptr_val[0 +: 16], 16'h0101);
        cyc("R11 idx0 big", 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b01, 0, 16'h0013);
        cyc("R4 stride 0x13", 1, 0, 2'b10, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        check("R4 upper value", ptr_val[0 +: 16], 16'h0114);

        // R5: negative strides on pointer 3, window of 16
        cyc("R11 mask3", 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b10, 3, 16'h000F);
        cyc("R11 ptr3", 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b00, 3, 16'h0021);
        cyc("R11 idx3", 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b01, 3, 16'hFFFB);
        cyc("R5 stride -5", 0, 0, 2'b00, 1, 3, 2'b10, 0, 2'b00, 0, 16'h0);
        check("R5 value", ptr_val[48 +: 16], 16'h002C);
        cyc("R11 idx3 big", 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b01, 3, 16'hFFED);
        cyc("R5 stride -0x13", 0, 0, 2'b00, 1, 3, 2'b10, 0, 2'b00, 0, 16'h0);
        check("R5 upper value", ptr_val[48 +: 16], 16'h0019);

        // R7: both lanes, different pointers and step codes
        cyc("R7 pair", 1, 0, 2'b01, 1, 3, 2'b10, 0, 2'b00, 0, 16'h0);
        cyc("R7 pair back", 1, 0, 2'b00, 1, 3, 2'b00, 0, 2'b00, 0, 16'h0);

        // R8: configuration write beats lane 0 on pointer 2
        cyc("R8 cfg wins", 1, 2, 2'b01, 0, 0, 2'b00, 1, 2'b00, 2, 16'h5555);
        check("R8 value", ptr_val[32 +: 16], 16'h5555);

        // R9: both lanes on pointer 1, lane 0 stored
        cyc("R9 same ptr", 1, 1, 2'b00, 1, 1, 2'b01, 0, 2'b00, 0, 16'h0);
        check("R9 value", ptr_val[16 +: 16], 16'hFFFF);

        // R10: hold leaves the pointer and reports it
        cyc("R10 hold", 1, 0, 2'b11, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);

        // R11: unused target changes nothing, later steps use old state
        cyc("R11 none tgt", 0, 0, 2'b00, 0, 0, 2'b00, 1, 2'b11, 0, 16'h1234);
        cyc("R11 after none", 1, 0, 2'b01, 1, 3, 2'b10, 0, 2'b00, 0, 16'h0);

        // R12: idle cycles keep all pointers
        cyc("R12 idle", 0, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
        cyc("R12 idle", 0, 0, 2'b00, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);

        n_tests++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R7: got %0d pending results expected 0", sb.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule